// File: doc/BRIEF.md
# Boot-Mirroring Chip-Select Decoder

This block turns a bus master's address into one of eight memory chip selects: four for static devices (flash, ROM, SRAM) and four for dynamic devices (SDRAM). The address space is divided into 256 MB windows. The dynamic selects take the four windows that start at address zero. The static selects take the four windows that start at `0x4000_0000`. A request in any other window asserts no select and raises a decode-error pulse. Every output is registered, so a select appears one clock after the request that caused it.

A processor starts fetching at address zero, but that window belongs to SDRAM, which is not usable at power-up. To cover this, the block comes out of reset with mirroring enabled. While mirroring is on, every access to the first dynamic window is sent to static select 1, where the boot flash sits. Boot software sets up the memory controller, then writes a one-cycle pulse on `mirror_off_i`. From the next cycle on, the first dynamic window decodes to dynamic select 0. If the boot-mode pin selects booting from SDRAM loaded over an SPI EEPROM, mirroring starts off.

Static select 1 also takes its configuration from pins that are sampled during reset. These pins set its select polarity, its byte-lane-enable polarity and its data width. All of them are held constant from the end of reset onwards.

Top module: `boot_cs_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every chip select is at its inactive level and `dec_err_o` is 0.
- R2: A request whose address bits [31:28] equal 4+i (i = 0..3) drives static select i (`st_cs_o[i]`) active in the next cycle, and no other select.
- R3: A request whose address bits [31:28] equal j (j = 1..3), or equal 0 while mirroring is off, drives dynamic select j (`dy_cs_o[j]`, active low) in the next cycle.
- R4: While `mirror_on_o` is 1, a request anywhere in the window with address bits [31:28] = 0 drives static select 1 active in the next cycle, and dynamic select 0 stays inactive.
- R5: A one-cycle pulse on `mirror_off_i` clears `mirror_on_o` from the next cycle on. The flag stays clear until the next reset.
- R6: `mirror_on_o` comes out of reset equal to the boot-mode pin: 1 means boot from flash or ROM (mirroring on), 0 means boot from SDRAM (mirroring off).
- R7: The static-select-1 polarity pin is inverted. Pin 1 gives `st1_cs_high_o` = 0, an active-low select that idles high. Pin 0 gives `st1_cs_high_o` = 1, an active-high select that idles low. All other selects are always active low.
- R8: `st1_be_high_o` equals the inverse of the byte-lane polarity pin: pin 1 means active low, pin 0 means active high.
- R9: Width pins 00, 01 and 10 give `st1_width_o` = 00 (8 bit), 01 (16 bit) and 10 (32 bit). Pins 11 give `st1_width_o` = 10 and set `cfg_err_o` = 1, and `cfg_err_o` then stays at 1 until the next reset.
- R10: The strap pins are captured in the last reset cycle. Changing them after reset has no effect on `st1_cs_high_o`, `st1_be_high_o`, `st1_width_o`, `cfg_err_o` or the select levels.
- R11: A request whose address falls in no enabled window drives `dec_err_o` to 1 for one cycle in the next cycle, with every select inactive.
- R12: In every cycle, at most one chip select is at its active level.
- R13: In a cycle after which no request was presented, every select is inactive and `dec_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap pins sampled while high |
| req_valid_i | input | 1 | A bus request is present this cycle |
| req_addr_i | input | 32 | Request byte address |
| mirror_off_i | input | 1 | Software pulse that disables boot mirroring |
| pin_cs1_pol_i | input | 1 | Static select 1 polarity strap (inverted) |
| pin_cs1_be_pol_i | input | 1 | Static select 1 byte-lane polarity strap (inverted) |
| pin_cs1_width_i | input | 2 | Static select 1 width strap |
| pin_boot_flash_i | input | 1 | Boot-mode strap, 1 = flash/ROM |
| st_cs_o | output | 4 | Static chip selects, pin levels |
| dy_cs_o | output | 4 | Dynamic chip selects, active low |
| dec_err_o | output | 1 | One-cycle pulse on an unmapped request |
| mirror_on_o | output | 1 | Boot mirroring currently enabled |
| st1_cs_high_o | output | 1 | Static select 1 is active high |
| st1_be_high_o | output | 1 | Static select 1 byte lanes are active high |
| st1_width_o | output | 2 | Static select 1 data width code |
| cfg_err_o | output | 1 | Sticky flag for an undefined width strap |

## Verification
The decode is driven with addresses at the start, in the middle and at the last word of static and dynamic windows. These show that only bits [31:28] choose a select and that each window maps to its own select. The zero window is driven three ways: with mirroring on, after the clear pulse, and after a reset with the SDRAM boot strap. Together these separate redirection, its removal and its strap-controlled start state. Addresses above the mapped windows, and idle cycles, show the error pulse and the quiet state. Each strap combination is applied before reset and then flipped after it, which shows that the values are captured at reset and not followed live.

// File: rtl/boot_cs_decoder_pkg.sv
package boot_cs_decoder_pkg;

  typedef enum logic [1:0] {
    WIDTH_8  = 2'b00,
    WIDTH_16 = 2'b01,
    WIDTH_32 = 2'b10
  } cs_width_e;

  typedef struct packed {
    logic      cs_high;
    logic      be_high;
    cs_width_e width;
    logic      width_bad;
  } strap_cfg_t;

endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import boot_cs_decoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_cs_pol_i,
  input  logic       pin_be_pol_i,
  input  logic [1:0] pin_width_i,
  output strap_cfg_t cfg_o
);

  strap_cfg_t cfg_q;

  // Follows the pins while reset is held; keeps the last sample afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.cs_high   <= ~pin_cs_pol_i;
      cfg_q.be_high   <= ~pin_be_pol_i;
      cfg_q.width_bad <= &pin_width_i;
      case (pin_width_i)
        2'b00:   cfg_q.width <= WIDTH_8;
        2'b01:   cfg_q.width <= WIDTH_16;
        default: cfg_q.width <= WIDTH_32;
      endcase
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/mirror_ctrl.sv
module mirror_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pin_boot_flash_i,
  input  logic clear_i,
  output logic mirror_o
);

  logic mirror_q;

  always_ff @(posedge clk) begin
    if (rst)          mirror_q <= pin_boot_flash_i;
    else if (clear_i) mirror_q <= 1'b0;
  end

  assign mirror_o = mirror_q;

endmodule

// File: rtl/cs_region_decode.sv
module cs_region_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_W    = 28,
  parameter int          N_STA    = 4,
  parameter int          N_DYN    = 4,
  parameter int          STA_BASE = 4,
  parameter int          DYN_BASE = 0,
  parameter int          MIR_TGT  = 1,
  parameter logic [31:0] CS_EN    = 32'h0000_00FF
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mirror_i,
  output logic [N_STA-1:0]  st_hit_o,
  output logic [N_DYN-1:0]  dy_hit_o,
  output logic              miss_o
);

  logic [ADDR_W-1:0] win_idx;
  logic [N_STA-1:0]  st_raw;
  logic [N_DYN-1:0]  dy_raw;
  logic              boot_win;

  assign win_idx  = addr_i >> WIN_W;
  assign boot_win = valid_i && (win_idx == ADDR_W'(DYN_BASE));

  for (genvar i = 0; i < N_STA; i++) begin : g_sta
    assign st_raw[i] = valid_i && CS_EN[i] && (win_idx == ADDR_W'(STA_BASE + i));
    if (i == MIR_TGT) begin : g_tgt
      assign st_hit_o[i] = st_raw[i] | (mirror_i & boot_win);
    end else begin : g_plain
      assign st_hit_o[i] = st_raw[i];
    end
  end

  for (genvar j = 0; j < N_DYN; j++) begin : g_dyn
    assign dy_raw[j] = valid_i && CS_EN[N_STA + j] && (win_idx == ADDR_W'(DYN_BASE + j));
    if (j == 0) begin : g_src
      assign dy_hit_o[j] = dy_raw[j] & ~mirror_i;
    end else begin : g_plain
      assign dy_hit_o[j] = dy_raw[j];
    end
  end

  assign miss_o = valid_i && !(|st_hit_o) && !(|dy_hit_o);

endmodule

// File: rtl/cs_drive.sv
module cs_drive #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sel_i,
  input  logic         miss_i,
  input  logic [N-1:0] act_high_i,
  output logic [N-1:0] lvl_o,
  output logic         err_o
);

  logic [N-1:0] sel_q;
  logic         err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      err_q <= miss_i;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_pol
    assign lvl_o[k] = act_high_i[k] ? sel_q[k] : ~sel_q[k];
  end

  assign err_o = err_q;

endmodule

// File: rtl/boot_cs_decoder.sv
module boot_cs_decoder
  import boot_cs_decoder_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_W    = 28,
  parameter int          N_STA    = 4,
  parameter int          N_DYN    = 4,
  parameter int          STA_BASE = 4,
  parameter int          DYN_BASE = 0,
  parameter int          MIR_TGT  = 1,
  parameter logic [31:0] CS_EN    = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              mirror_off_i,
  input  logic              pin_cs1_pol_i,
  input  logic              pin_cs1_be_pol_i,
  input  logic [1:0]        pin_cs1_width_i,
  input  logic              pin_boot_flash_i,
  output logic [N_STA-1:0]  st_cs_o,
  output logic [N_DYN-1:0]  dy_cs_o,
  output logic              dec_err_o,
  output logic              mirror_on_o,
  output logic              st1_cs_high_o,
  output logic              st1_be_high_o,
  output logic [1:0]        st1_width_o,
  output logic              cfg_err_o
);

  localparam int N_CS = N_STA + N_DYN;

  strap_cfg_t       cfg;
  logic             mirror;
  logic [N_STA-1:0] st_hit;
  logic [N_DYN-1:0] dy_hit;
  logic             miss;
  logic [N_CS-1:0]  act_high;
  logic [N_CS-1:0]  lvl;

  strap_capture u_strap (
    .clk          (clk),
    .rst          (rst),
    .pin_cs_pol_i (pin_cs1_pol_i),
    .pin_be_pol_i (pin_cs1_be_pol_i),
    .pin_width_i  (pin_cs1_width_i),
    .cfg_o        (cfg)
  );

  mirror_ctrl u_mirror (
    .clk              (clk),
    .rst              (rst),
    .pin_boot_flash_i (pin_boot_flash_i),
    .clear_i          (mirror_off_i),
    .mirror_o         (mirror)
  );

  cs_region_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W),
    .N_STA    (N_STA),
    .N_DYN    (N_DYN),
    .STA_BASE (STA_BASE),
    .DYN_BASE (DYN_BASE),
    .MIR_TGT  (MIR_TGT),
    .CS_EN    (CS_EN)
  ) u_decode (
    .valid_i  (req_valid_i),
    .addr_i   (req_addr_i),
    .mirror_i (mirror),
    .st_hit_o (st_hit),
    .dy_hit_o (dy_hit),
    .miss_o   (miss)
  );

  // Only the boot target takes a strap-selected polarity.
  for (genvar k = 0; k < N_CS; k++) begin : g_act
    if (k == MIR_TGT) begin : g_strap
      assign act_high[k] = cfg.cs_high;
    end else begin : g_low
      assign act_high[k] = 1'b0;
    end
  end

  cs_drive #(
    .N (N_CS)
  ) u_drive (
    .clk        (clk),
    .rst        (rst),
    .sel_i      ({dy_hit, st_hit}),
    .miss_i     (miss),
    .act_high_i (act_high),
    .lvl_o      (lvl),
    .err_o      (dec_err_o)
  );

  assign st_cs_o       = lvl[N_STA-1:0];
  assign dy_cs_o       = lvl[N_CS-1:N_STA];
  assign mirror_on_o   = mirror;
  assign st1_cs_high_o = cfg.cs_high;
  assign st1_be_high_o = cfg.be_high;
  assign st1_width_o   = cfg.width;
  assign cfg_err_o     = cfg.width_bad;

endmodule

// File: rtl/boot_cs_decoder_chk.sv
module boot_cs_decoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_W    = 28,
  parameter int N_STA    = 4,
  parameter int N_DYN    = 4,
  parameter int STA_BASE = 4,
  parameter int DYN_BASE = 0,
  parameter int MIR_TGT  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              mirror_off_i,
  input logic [N_STA-1:0]  st_cs_o,
  input logic [N_DYN-1:0]  dy_cs_o,
  input logic              dec_err_o,
  input logic              mirror_on_o,
  input logic              st1_cs_high_o,
  input logic              st1_be_high_o,
  input logic [1:0]        st1_width_o,
  input logic              cfg_err_o
);

  logic [N_STA-1:0]  st_act;
  logic [N_STA-1:0]  st_on;
  logic [N_DYN-1:0]  dy_on;
  logic [ADDR_W-1:0] win;
  logic              in_sta;
  logic              in_dyn;

  always_comb begin
    st_act          = '0;
    st_act[MIR_TGT] = st1_cs_high_o;
  end

  assign st_on  = st_cs_o ~^ st_act;
  assign dy_on  = ~dy_cs_o;
  assign win    = req_addr_i >> WIN_W;
  assign in_sta = (win - ADDR_W'(STA_BASE)) < ADDR_W'(N_STA);
  assign in_dyn = (win - ADDR_W'(DYN_BASE)) < ADDR_W'(N_DYN);

  // R12
  onehot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_on, dy_on}));

  // R4
  mirror_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && mirror_on_o && win == ADDR_W'(DYN_BASE))
      |=> (st_on[MIR_TGT] && !dy_on[0]));

  // R5
  mirror_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mirror_off_i |=> !mirror_on_o);

  // R11
  unmapped_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !in_sta && !in_dyn) |=> (dec_err_o && !(|st_on) && !(|dy_on)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (!(|st_on) && !(|dy_on) && !dec_err_o));

  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable({st1_cs_high_o, st1_be_high_o, st1_width_o, cfg_err_o}));

  // R9
  bad_width_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (st1_width_o == 2'b10));

endmodule

bind boot_cs_decoder boot_cs_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_W    (WIN_W),
  .N_STA    (N_STA),
  .N_DYN    (N_DYN),
  .STA_BASE (STA_BASE),
  .DYN_BASE (DYN_BASE),
  .MIR_TGT  (MIR_TGT)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid_i   (req_valid_i),
  .req_addr_i    (req_addr_i),
  .mirror_off_i  (mirror_off_i),
  .st_cs_o       (st_cs_o),
  .dy_cs_o       (dy_cs_o),
  .dec_err_o     (dec_err_o),
  .mirror_on_o   (mirror_on_o),
  .st1_cs_high_o (st1_cs_high_o),
  .st1_be_high_o (st1_be_high_o),
  .st1_width_o   (st1_width_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/boot_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module boot_cs_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        mirror_off_i = 1'b0;
  logic        pin_cs1_pol_i = 1'b1;
  logic        pin_cs1_be_pol_i = 1'b1;
  logic [1:0]  pin_cs1_width_i = 2'b10;
  logic        pin_boot_flash_i = 1'b1;
  logic [3:0]  st_cs_o;
  logic [3:0]  dy_cs_o;
  logic        dec_err_o;
  logic        mirror_on_o;
  logic        st1_cs_high_o;
  logic        st1_be_high_o;
  logic [1:0]  st1_width_o;
  logic        cfg_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit hi     = 1'b0;

  always #5 clk = ~clk;

  boot_cs_decoder dut_i (
    .clk              (clk),
    .rst              (rst),
    .req_valid_i      (req_valid_i),
    .req_addr_i       (req_addr_i),
    .mirror_off_i     (mirror_off_i),
    .pin_cs1_pol_i    (pin_cs1_pol_i),
    .pin_cs1_be_pol_i (pin_cs1_be_pol_i),
    .pin_cs1_width_i  (pin_cs1_width_i),
    .pin_boot_flash_i (pin_boot_flash_i),
    .st_cs_o          (st_cs_o),
    .dy_cs_o          (dy_cs_o),
    .dec_err_o        (dec_err_o),
    .mirror_on_o      (mirror_on_o),
    .st1_cs_high_o    (st1_cs_high_o),
    .st1_be_high_o    (st1_be_high_o),
    .st1_width_o      (st1_width_o),
    .cfg_err_o        (cfg_err_o)
  );

  function automatic logic [3:0] st_idle(bit h);
    return h ? 4'b1101 : 4'b1111;
  endfunction

  function automatic logic [3:0] st_pick(int i, bit h);
    return st_idle(h) ^ (4'b0001 << i);
  endfunction

  function automatic logic [3:0] dy_pick(int j);
    return 4'b1111 ^ (4'b0001 << j);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit cs_pol, bit be_pol, logic [1:0] w, bit boot);
    @(negedge clk);
    pin_cs1_pol_i    = cs_pol;
    pin_cs1_be_pol_i = be_pol;
    pin_cs1_width_i  = w;
    pin_boot_flash_i = boot;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hi  = ~cs_pol;
  endtask

  // Presents one request and checks the registered result one cycle later.
  task automatic request(string tag, logic [31:0] a, logic [3:0] est, logic [3:0] edy, bit eerr);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    check({tag, " st_cs"}, 32'(st_cs_o), 32'(est));
    check({tag, " dy_cs"}, 32'(dy_cs_o), 32'(edy));
    check({tag, " dec_err"}, 32'(dec_err_o), 32'(eerr));
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 st_cs in reset", 32'(st_cs_o), 32'hF);
    check("R1 dy_cs in reset", 32'(dy_cs_o), 32'hF);
    do_reset(1'b1, 1'b1, 2'b10, 1'b1);
    check("R1 st_cs after reset", 32'(st_cs_o), 32'(st_idle(hi)));
    check("R1 dy_cs after reset", 32'(dy_cs_o), 32'hF);
    check("R1 dec_err after reset", 32'(dec_err_o), 32'd0);
    check("R6 mirror on with flash boot", 32'(mirror_on_o), 32'd1);
    check("R7 cs1 active low with pin 1", 32'(st1_cs_high_o), 32'd0);
    check("R8 lanes active low with pin 1", 32'(st1_be_high_o), 32'd0);
    check("R9 width 32 with pins 10", 32'(st1_width_o), 32'd2);
    check("R9 no cfg error", 32'(cfg_err_o), 32'd0);
  endtask

  task automatic t_static_windows();
    for (int i = 0; i < 4; i++) begin
      request("R2 static base", 32'h4000_0000 + (32'(i) << 28), st_pick(i, hi), 4'hF, 1'b0);
      request("R2 static top", 32'h4FFF_FFFC + (32'(i) << 28), st_pick(i, hi), 4'hF, 1'b0);
    end
  endtask

  task automatic t_dynamic_windows();
    for (int j = 1; j < 4; j++)
      request("R3 dynamic", 32'h0000_1230 + (32'(j) << 28), st_idle(hi), dy_pick(j), 1'b0);
  endtask

  task automatic t_mirror();
    request("R4 mirror at zero", 32'h0000_0000, st_pick(1, hi), 4'hF, 1'b0);
    request("R4 mirror at window top", 32'h0FFF_FFFC, st_pick(1, hi), 4'hF, 1'b0);
    request("R12 back-to-back static 3", 32'h7000_0040, st_pick(3, hi), 4'hF, 1'b0);
  endtask

  task automatic t_unmapped();
    request("R11 unmapped", 32'h9000_0000, st_idle(hi), 4'hF, 1'b1);
    @(negedge clk);
    check("R11 error is one pulse", 32'(dec_err_o), 32'd0);
    request("R11 top of space", 32'hFFFF_FFFC, st_idle(hi), 4'hF, 1'b1);
  endtask

  task automatic t_idle();
    repeat (3) @(negedge clk);
    check("R13 idle st_cs", 32'(st_cs_o), 32'(st_idle(hi)));
    check("R13 idle dy_cs", 32'(dy_cs_o), 32'hF);
    check("R13 idle dec_err", 32'(dec_err_o), 32'd0);
  endtask

  task automatic t_mirror_clear();
    @(negedge clk);
    mirror_off_i = 1'b1;
    @(negedge clk);
    mirror_off_i = 1'b0;
    check("R5 mirror cleared", 32'(mirror_on_o), 32'd0);
    request("R5 zero goes to dynamic 0", 32'h0000_0100, st_idle(hi), dy_pick(0), 1'b0);
    request("R3 dynamic 0 normal", 32'h0ABC_DEF0, st_idle(hi), dy_pick(0), 1'b0);
    repeat (4) @(negedge clk);
    check("R5 mirror stays clear", 32'(mirror_on_o), 32'd0);
  endtask

  task automatic t_alt_straps();
    do_reset(1'b0, 1'b0, 2'b01, 1'b0);
    check("R6 mirror off with SDRAM boot", 32'(mirror_on_o), 32'd0);
    check("R7 cs1 active high with pin 0", 32'(st1_cs_high_o), 32'd1);
    check("R7 cs1 idles low", 32'(st_cs_o), 32'(st_idle(1'b1)));
    check("R8 lanes active high with pin 0", 32'(st1_be_high_o), 32'd1);
    check("R9 width 16 with pins 01", 32'(st1_width_o), 32'd1);
    request("R6 zero decodes dynamic 0", 32'h0000_0000, st_idle(hi), dy_pick(0), 1'b0);
    request("R7 cs1 drives high", 32'h5000_0000, st_pick(1, hi), 4'hF, 1'b0);
    request("R7 cs0 still active low", 32'h4000_0000, st_pick(0, hi), 4'hF, 1'b0);
    @(negedge clk);
    pin_cs1_pol_i    = 1'b1;
    pin_cs1_be_pol_i = 1'b1;
    pin_cs1_width_i  = 2'b11;
    pin_boot_flash_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 polarity held", 32'(st1_cs_high_o), 32'd1);
    check("R10 lane polarity held", 32'(st1_be_high_o), 32'd1);
    check("R10 width held", 32'(st1_width_o), 32'd1);
    check("R10 cfg error held", 32'(cfg_err_o), 32'd0);
    check("R10 mirror held", 32'(mirror_on_o), 32'd0);
    request("R10 cs1 level held", 32'h5000_0010, st_pick(1, 1'b1), 4'hF, 1'b0);
  endtask

  task automatic t_widths();
    do_reset(1'b1, 1'b1, 2'b00, 1'b1);
    check("R9 width 8 with pins 00", 32'(st1_width_o), 32'd0);
    check("R9 no error with pins 00", 32'(cfg_err_o), 32'd0);
    do_reset(1'b1, 1'b1, 2'b11, 1'b1);
    check("R9 undefined falls back to 32", 32'(st1_width_o), 32'd2);
    check("R9 cfg error raised", 32'(cfg_err_o), 32'd1);
    pin_cs1_width_i = 2'b00;
    request("R4 mirror after second reset", 32'h0000_0020, st_pick(1, hi), 4'hF, 1'b0);
    check("R9 cfg error sticky", 32'(cfg_err_o), 32'd1);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_static_windows();
    t_mirror();
    t_dynamic_windows();
    t_unmapped();
    t_idle();
    t_mirror_clear();
    t_alt_straps();
    t_widths();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule